// File: doc/BRIEF.md
# UART Register Front End with Prioritized Interrupt

This block is the register side of a small UART. A processor reaches it over a 32-bit word-addressed bus with separate read and write strobes and a byte-enable field. Through that bus it can pick up a received byte, send a byte, set which events may interrupt, read which event is currently interrupting, and look at line and modem status. The block sends one level interrupt request to the processor. When several enabled events are active at once, a fixed four-level priority chooses one, and its code is shown in the identification register.

Bytes come in from the receive side on a valid/ready handshake and are kept in a single holding register. There is no FIFO. If a byte is offered while the previous one has not been read yet, the block flags an overrun. Bytes written by the processor leave at once as a one-cycle strobe with the byte. Parity, framing, break and modem conditions are produced outside the block and reach it on input ports. The block registers them for one cycle before they appear in the status registers.

Top module: `uart_regfront`

## Requirements
- R1: After reset the interrupt enable register reads 0, the identification register reads 0x1, the line status register reads 0x60 (bit 5 transmit holding empty and bit 6 transmitter empty set), the modem status register reads 0, `irq` is low and `rx_ready` is high.
- R2: Registers are selected by word index on `bus_addr`: 0 data, 1 interrupt enable, 2 identification, 3 line status, 4 modem status. Read data appears on `bus_rdata` in the cycle after the read strobe. Line status bits: 0 data ready, 1 overrun, 2 parity, 3 framing, 4 break. Enable bits: 0 received data, 1 transmit empty, 2 line status, 3 modem.
- R3: When `rx_valid` is high while `rx_ready` is high, the byte is held, data ready is set, and `rx_ready` is low from the next cycle.
- R4: A full-width read of the data register returns the held byte and clears data ready, so `rx_ready` is high again in the next cycle.
- R5: When `rx_valid` is high while data ready is set, the offered byte is dropped, the held byte is kept and the overrun bit is set. A read of the line status register returns the overrun bit and then clears it.
- R6: A full-width write to the data register gives `tx_valid` high for exactly one cycle in the next cycle, with `tx_byte` equal to the low byte of the written word.
- R7: Top priority: if enable bit 2 is set and any of overrun, parity, framing or break is set, `irq` is high and the identification register reads 0x6.
- R8: Second priority: data ready with enable bit 0 set gives `irq` high and identification 0x4.
- R9: Third priority: transmit holding empty with enable bit 1 set gives `irq` high and identification 0x2.
- R10: Fourth priority: a nonzero value in bits 3..0 of modem status with enable bit 3 set gives `irq` high and identification 0x0. Bits 7..4 alone raise nothing.
- R11: With no enabled event active, `irq` is low and the identification register reads 0x1.
- R12: An access whose `bus_be` is not all ones changes no state, sends no byte, returns 0 on a read, and pulses `bus_err` high for one cycle in the next cycle.
- R13: A write to the identification, line status or modem status register, any access to an index above 4, and a cycle with both strobes high are ignored (reads return 0) and pulse `bus_err` for one cycle. Valid accesses leave `bus_err` low.
- R14: The parity, framing, break and modem inputs show up in the status registers, and in `irq`, one clock cycle after they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_be | input | BUS_W/8 | Byte enables; must be all ones |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| bus_err | output | 1 | One-cycle pulse on an ignored access |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | BYTE_W | Received byte |
| rx_ready | output | 1 | High while the holding register is empty |
| tx_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_byte | output | BYTE_W | Outgoing byte |
| st_parity | input | 1 | Parity error condition |
| st_framing | input | 1 | Framing error condition |
| st_break | input | 1 | Break condition |
| modem_st | input | MSR_W | Modem status bits |
| irq | output | 1 | Level interrupt request |

## Verification
Most internal faults in this block show up at the ports within one or two cycles. A data-ready flag stuck high holds `rx_ready` low in the cycle after the byte is taken. A lost overrun flag shows up in the very next line status read. A wrong priority order returns the wrong identification code on the first read where two enabled events overlap. A wrong decode either gives a `tx_valid` strobe that should not happen or misses one, which the scoreboard queue catches. It also shows up as `bus_err` pulsing, or staying low, in the cycle after the bad access.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_IER  = 3'd1,
    REG_IIR  = 3'd2,
    REG_LSR  = 3'd3,
    REG_MSR  = 3'd4
  } reg_idx_e;

  // line status bit positions
  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LSR_W    = 8;

  // interrupt enable bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;
  localparam int EN_W    = 4;

  // identification codes: bit0 = nothing pending, bits2:1 = source id
  localparam int IIR_W = 3;
  localparam logic [IIR_W-1:0] IIR_NONE = 3'b001;
  localparam logic [IIR_W-1:0] IIR_LINE = 3'b110;
  localparam logic [IIR_W-1:0] IIR_RXD  = 3'b100;
  localparam logic [IIR_W-1:0] IIR_THR  = 3'b010;
  localparam logic [IIR_W-1:0] IIR_MDM  = 3'b000;

  localparam int NUM_SRC = 4;

  typedef struct packed {
    logic rd_data;
    logic rd_ier;
    logic rd_iir;
    logic rd_lsr;
    logic rd_msr;
    logic wr_data;
    logic wr_ier;
    logic bad;
  } acc_s;

endpackage

// File: rtl/uart_regfront_decode.sv
module uart_regfront_decode
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BE_W   = 4
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output acc_s              acc
);

  logic any_acc;
  logic one_acc;
  logic full_be;

  assign any_acc = rd | wr;
  assign one_acc = rd ^ wr;
  assign full_be = &be;

  always_comb begin
    acc = '0;
    if (any_acc) begin
      if (!full_be || !one_acc) begin
        acc.bad = 1'b1;
      end else if (rd) begin
        if (addr == ADDR_W'(REG_DATA))      acc.rd_data = 1'b1;
        else if (addr == ADDR_W'(REG_IER))  acc.rd_ier  = 1'b1;
        else if (addr == ADDR_W'(REG_IIR))  acc.rd_iir  = 1'b1;
        else if (addr == ADDR_W'(REG_LSR))  acc.rd_lsr  = 1'b1;
        else if (addr == ADDR_W'(REG_MSR))  acc.rd_msr  = 1'b1;
        else                                acc.bad     = 1'b1;
      end else begin
        if (addr == ADDR_W'(REG_DATA))      acc.wr_data = 1'b1;
        else if (addr == ADDR_W'(REG_IER))  acc.wr_ier  = 1'b1;
        else                                acc.bad     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_regfront_rxhold.sv
module uart_regfront_rxhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              take,
  input  logic              clr_ovr,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] held,
  output logic              dr,
  output logic              ovr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      dr   <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (rx_valid && !dr) begin
        held <= rx_byte;
        dr   <= 1'b1;
      end else if (take) begin
        dr   <= 1'b0;
      end
      if (rx_valid && dr) begin
        ovr <= 1'b1;
      end else if (clr_ovr) begin
        ovr <= 1'b0;
      end
    end
  end

  assign rx_ready = !dr;

endmodule

// File: rtl/uart_regfront_irqprio.sv
module uart_regfront_irqprio
  import uart_regfront_pkg::*;
(
  input  logic [LSR_W-1:0] lsr,
  input  logic [EN_W-1:0]  en,
  input  logic             mdm_any,
  output logic             irq,
  output logic [IIR_W-1:0] iir
);

  logic [NUM_SRC-1:0] hit;

  // index 0 is the highest priority
  assign hit[0] = en[EN_LINE] &
                  (lsr[LSR_OE] | lsr[LSR_PE] | lsr[LSR_FE] | lsr[LSR_BI]);
  assign hit[1] = en[EN_RXD] & lsr[LSR_DR];
  assign hit[2] = en[EN_THR] & lsr[LSR_THRE];
  assign hit[3] = en[EN_MDM] & mdm_any;

  function automatic logic [IIR_W-1:0] src_code(input int idx);
    case (idx)
      0:       return IIR_LINE;
      1:       return IIR_RXD;
      2:       return IIR_THR;
      default: return IIR_MDM;
    endcase
  endfunction

  always_comb begin
    irq = 1'b0;
    iir = IIR_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) begin
        irq = 1'b1;
        iir = src_code(i);
      end
    end
  end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  parameter int MSR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W/8-1:0]   bus_be,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 bus_err,
  input  logic                 rx_valid,
  input  logic [BYTE_W-1:0]    rx_byte,
  output logic                 rx_ready,
  output logic                 tx_valid,
  output logic [BYTE_W-1:0]    tx_byte,
  input  logic                 st_parity,
  input  logic                 st_framing,
  input  logic                 st_break,
  input  logic [MSR_W-1:0]     modem_st,
  output logic                 irq
);

  localparam int BE_W  = BUS_W / 8;
  localparam int MLO_W = (MSR_W < 4) ? MSR_W : 4;

  acc_s              acc;
  logic [EN_W-1:0]   ier_q;
  logic              pe_q, fe_q, bi_q;
  logic [MSR_W-1:0]  msr_q;
  logic [BYTE_W-1:0] held;
  logic              dr, ovr;
  logic [LSR_W-1:0]  lsr_vec;
  logic [IIR_W-1:0]  iir_code;
  logic [BUS_W-1:0]  rd_val;

  uart_regfront_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .rd   (bus_rd),
    .wr   (bus_wr),
    .addr (bus_addr),
    .be   (bus_be),
    .acc  (acc)
  );

  uart_regfront_rxhold #(.BYTE_W(BYTE_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .take     (acc.rd_data),
    .clr_ovr  (acc.rd_lsr),
    .rx_ready (rx_ready),
    .held     (held),
    .dr       (dr),
    .ovr      (ovr)
  );

  always_comb begin
    lsr_vec           = '0;
    lsr_vec[LSR_DR]   = dr;
    lsr_vec[LSR_OE]   = ovr;
    lsr_vec[LSR_PE]   = pe_q;
    lsr_vec[LSR_FE]   = fe_q;
    lsr_vec[LSR_BI]   = bi_q;
    lsr_vec[LSR_THRE] = 1'b1;
    lsr_vec[LSR_TEMT] = 1'b1;
  end

  uart_regfront_irqprio u_prio (
    .lsr     (lsr_vec),
    .en      (ier_q),
    .mdm_any (|msr_q[MLO_W-1:0]),
    .irq     (irq),
    .iir     (iir_code)
  );

  always_comb begin
    rd_val = '0;
    if (acc.rd_data) rd_val = BUS_W'(held);
    if (acc.rd_ier)  rd_val = BUS_W'(ier_q);
    if (acc.rd_iir)  rd_val = BUS_W'(iir_code);
    if (acc.rd_lsr)  rd_val = BUS_W'(lsr_vec);
    if (acc.rd_msr)  rd_val = BUS_W'(msr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q     <= '0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      bi_q      <= 1'b0;
      msr_q     <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
    end else begin
      pe_q     <= st_parity;
      fe_q     <= st_framing;
      bi_q     <= st_break;
      msr_q    <= modem_st;
      bus_err  <= acc.bad;
      tx_valid <= acc.wr_data;
      if (acc.wr_data) tx_byte <= bus_wdata[BYTE_W-1:0];
      if (acc.wr_ier)  ier_q   <= bus_wdata[EN_W-1:0];
      if (bus_rd)      bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W/8-1:0] bus_be,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_err,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              irq,
  input logic [3:0]        ier_q,
  input logic [BYTE_W-1:0] held,
  input logic              ovr
);

  p_rx_load_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready |=> !rx_ready && held == $past(rx_byte));

  p_overrun_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready |=> ovr && $stable(held));

  p_tx_send_r6: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !bus_rd && bus_addr == '0 && (&bus_be)
      |=> tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0]));

  p_tx_cause_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_wr));

  p_line_irq_r7: assert property (@(posedge clk) disable iff (rst)
    ier_q[2] && ovr |-> irq);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ier_q == 4'd0 |-> !irq);

  p_partial_err_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) && !(&bus_be) |=> bus_err && !tx_valid);

endmodule

bind uart_regfront uart_regfront_chk #(
  .ADDR_W (ADDR_W),
  .BUS_W  (BUS_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_byte   (tx_byte),
  .irq       (irq),
  .ier_q     (ier_q),
  .held      (held),
  .ovr       (ovr)
);

// File: tb/test_uart_regfront.sv
`timescale 1ns/1ps
module test_uart_regfront;

  localparam int ADDR_W = 3;
  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;
  localparam int MSR_W  = 8;
  localparam int BE_W   = BUS_W / 8;
  localparam logic [BE_W-1:0] BE_ALL = '1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_rd = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [BE_W-1:0]   bus_be = '0;
  logic [BUS_W-1:0]  bus_wdata = '0;
  logic [BUS_W-1:0]  bus_rdata;
  logic              bus_err;
  logic              rx_valid = 1'b0;
  logic [BYTE_W-1:0] rx_byte = '0;
  logic              rx_ready;
  logic              tx_valid;
  logic [BYTE_W-1:0] tx_byte;
  logic              st_parity = 1'b0, st_framing = 1'b0, st_break = 1'b0;
  logic [MSR_W-1:0]  modem_st = '0;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [BYTE_W-1:0] tx_q[$];

  always #2.5 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W), .MSR_W(MSR_W)) i_uart_regfront (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .st_parity(st_parity),
    .st_framing(st_framing), .st_break(st_break), .modem_st(modem_st), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: every accepted data write pushes its expected byte
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                    input logic [BE_W-1:0] be, output logic err);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    if (a == '0 && be == BE_ALL) tx_q.push_back(d[BYTE_W-1:0]);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    err = bus_err;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [BE_W-1:0] be,
                    output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = '0;
    d = bus_rdata; err = bus_err;
  endtask

  task automatic rx_push(input logic [BYTE_W-1:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // monitor: each transmit strobe must match the oldest expected byte
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (tx_q.size() == 0) begin
        check("R6 unexpected tx strobe", {24'h0, tx_byte}, 32'hFFFF_FFFF);
      end else begin
        check("R6 tx byte", {24'h0, tx_byte}, {24'h0, tx_q.pop_front()});
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    rd(3'd1, BE_ALL, d, e); check("R1 ier", d, 32'h0);
    rd(3'd2, BE_ALL, d, e); check("R1 iir", d, 32'h1);
    rd(3'd3, BE_ALL, d, e); check("R1 R2 lsr", d, 32'h60);
    check("R13 valid access no err", {31'h0, e}, 32'h0);
    rd(3'd4, BE_ALL, d, e); check("R1 msr", d, 32'h0);
    check("R11 idle irq", {31'h0, irq}, 32'h0);

    // R6 transmit
    wr(3'd0, 32'h1234_55A5, BE_ALL, e);
    wr(3'd0, 32'h0000_003C, BE_ALL, e);
    @(negedge clk);
    check("R6 single pulse", {31'h0, tx_valid}, 32'h0);

    // R12 partial write to data: no strobe, error
    wr(3'd0, 32'h0000_0099, 4'h1, e);
    check("R12 partial write err", {31'h0, e}, 32'h1);
    @(negedge clk);
    check("R12 err one cycle", {31'h0, bus_err}, 32'h0);

    // R3 receive
    rx_push(8'h3C);
    check("R3 ready low", {31'h0, rx_ready}, 32'h0);
    rd(3'd3, BE_ALL, d, e); check("R3 lsr dr", d, 32'h61);

    // R12 partial read of data keeps the byte
    rd(3'd0, 4'h3, d, e);
    check("R12 partial read zero", d, 32'h0);
    check("R12 partial read err", {31'h0, e}, 32'h1);
    check("R12 dr kept", {31'h0, rx_ready}, 32'h0);

    // R5 overrun
    rx_push(8'hD2);
    rd(3'd3, BE_ALL, d, e); check("R5 overrun seen", d, 32'h63);
    rd(3'd3, BE_ALL, d, e); check("R5 overrun cleared", d, 32'h61);
    rd(3'd0, BE_ALL, d, e); check("R5 R4 held byte kept", d, 32'h3C);
    check("R4 ready again", {31'h0, rx_ready}, 32'h1);
    rd(3'd3, BE_ALL, d, e); check("R4 dr cleared", d, 32'h60);

    // R8 received data interrupt
    wr(3'd1, 32'h1, BE_ALL, e);
    check("R8 no data no irq", {31'h0, irq}, 32'h0);
    rx_push(8'h77);
    check("R8 irq", {31'h0, irq}, 32'h1);
    rd(3'd2, BE_ALL, d, e); check("R8 iir", d, 32'h4);
    rd(3'd0, BE_ALL, d, e); check("R4 data", d, 32'h77);
    check("R11 irq drops", {31'h0, irq}, 32'h0);
    rd(3'd2, BE_ALL, d, e); check("R11 iir none", d, 32'h1);

    // R9 transmit empty interrupt
    wr(3'd1, 32'h2, BE_ALL, e);
    check("R9 irq", {31'h0, irq}, 32'h1);
    rd(3'd2, BE_ALL, d, e); check("R9 iir", d, 32'h2);

    // R7 priority over data and transmit empty
    wr(3'd1, 32'h7, BE_ALL, e);
    rx_push(8'h11);
    @(negedge clk);
    st_parity = 1'b1;
    @(negedge clk);
    rd(3'd2, BE_ALL, d, e); check("R7 line wins", d, 32'h6);
    st_parity = 1'b0;
    @(negedge clk);
    rd(3'd2, BE_ALL, d, e); check("R8 data below line", d, 32'h4);
    rd(3'd0, BE_ALL, d, e);
    rd(3'd2, BE_ALL, d, e); check("R9 thre below data", d, 32'h2);

    // R14 input latency on break
    wr(3'd1, 32'h4, BE_ALL, e);
    @(negedge clk);
    st_break = 1'b1;
    #0.1;
    check("R14 not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R14 one cycle later", {31'h0, irq}, 32'h1);
    st_break = 1'b0;
    st_framing = 1'b1;
    @(negedge clk);
    rd(3'd3, BE_ALL, d, e); check("R14 R7 framing in lsr", d, 32'h68);
    st_framing = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 clears", {31'h0, irq}, 32'h0);

    // R10 modem interrupt
    wr(3'd1, 32'h8, BE_ALL, e);
    modem_st = 8'hF0;
    @(negedge clk);
    @(negedge clk);
    check("R10 upper bits ignored", {31'h0, irq}, 32'h0);
    modem_st = 8'h04;
    @(negedge clk);
    @(negedge clk);
    check("R10 irq", {31'h0, irq}, 32'h1);
    rd(3'd2, BE_ALL, d, e); check("R10 iir", d, 32'h0);
    rd(3'd4, BE_ALL, d, e); check("R10 msr", d, 32'h04);
    modem_st = 8'h00;

    // R13 ignored accesses
    wr(3'd2, 32'hFF, BE_ALL, e); check("R13 write iir err", {31'h0, e}, 32'h1);
    wr(3'd3, 32'hFF, BE_ALL, e); check("R13 write lsr err", {31'h0, e}, 32'h1);
    rd(3'd3, BE_ALL, d, e); check("R13 lsr unchanged", d, 32'h60);
    rd(3'd5, BE_ALL, d, e);
    check("R13 unmapped read zero", d, 32'h0);
    check("R13 unmapped read err", {31'h0, e}, 32'h1);
    wr(3'd7, 32'h1, BE_ALL, e); check("R13 unmapped write err", {31'h0, e}, 32'h1);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_be = BE_ALL; bus_wdata = 32'hF;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_be = '0;
    check("R13 both strobes err", {31'h0, bus_err}, 32'h1);
    wr(3'd1, 32'h1, 4'hE, e); check("R12 partial ier err", {31'h0, e}, 32'h1);
    rd(3'd1, BE_ALL, d, e); check("R12 R13 ier unchanged", d, 32'h8);

    repeat (3) @(negedge clk);
    check("R6 queue drained", tx_q.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule